// File: doc/BRIEF.md
# Serial Systematic BCH Encoder

This block turns a stream of message bits into BCH codewords one bit per clock. Message bits arrive on a valid/ready input. Each accepted bit is passed through to a registered valid/ready output, and at the same time it is folded into a parity shift register that divides by the generator polynomial. After the last message bit, the input is held off while the parity remainder is shifted out behind the data. The codeword is therefore systematic: data first, parity after.

The default build is the binary (15,7) code over GF(2^4) that corrects two errors, with generator x^8+x^7+x^6+x^4+1. The field exponent, the error count, the parity length and the generator are parameters. The message length defaults to the full length for that code and can be set lower to give a shortened code. A start pulse on the input begins a new word at any point, a clock enable freezes the whole block, and a synchronous reset returns it to an idle, empty state.

Top module: `bch_serial_enc`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears: after that edge `out_valid` and `out_start` are 0, and with `en` high `in_ready` is 1.
- R2: Each codeword is the K message bits in arrival order, followed by PAR_W parity bits. The first message bit is the highest-power coefficient. The parity is the remainder of message·x^PAR_W divided by GEN_POLY (default 9'h1D1), sent from the x^(PAR_W-1) coefficient down to x^0. For example, the default message 0000001 gives parity 11010001.
- R3: Once the last message bit has been accepted, `in_ready` stays low for the parity tail. With `en` and `out_ready` held high, this lasts exactly PAR_W cycles.
- R4: `out_start` is high only with the first bit of each codeword. An `in_start` pulse in the middle of a word clears the parity state and the bit count. The bit carrying the pulse becomes the first bit of a new word. Bits already accepted from the cut-short word are still emitted as plain data bits.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bit` and `out_start` hold their values.
- R6: A bit accepted at a clock edge appears on `out_bit` with `out_valid` high right after that edge, a latency of one clock.
- R7: While `en` is low, `in_ready` is low and no transfer occurs on either side. Input valid, data and start are ignored, and the output and all internal state hold.
- R8: Every complete codeword the block emits, read as a polynomial with its first bit as the highest power, is divisible by GEN_POLY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; low freezes the block |
| in_valid | input | 1 | Message bit on `in_bit` is valid |
| in_ready | output | 1 | Block can accept a message bit |
| in_bit | input | 1 | Message bit |
| in_start | input | 1 | Marks the first message bit of a word |
| out_valid | output | 1 | Codeword bit on `out_bit` is valid |
| out_ready | input | 1 | Sink can accept a codeword bit |
| out_bit | output | 1 | Codeword bit |
| out_start | output | 1 | Marks the first bit of a codeword |

## Verification
Four kinds of message drive the encoder. A lone trailing one has a remainder equal to the generator's low bits. A lone leading one exercises the longest feedback chain. All-zero and all-one words show whether parity stays zero or saturates the taps, and an alternating pattern plus pseudo-random words mix the feedback terms. Every word is also checked for divisibility as it is emitted, which separates a wrong tap from a wrong output order. The same words are sent with a randomly stalling sink to exercise the hold rules. Further cases cover a word cut short by a fresh start pulse, enable dropped in the middle of a word with garbage on the input, and a reset in the middle of the parity tail. Together these show whether partial state leaks into the next codeword.

// File: rtl/bch_enc_pkg.sv
`timescale 1ns/1ps
package bch_enc_pkg;
  typedef enum logic {
    PH_DATA   = 1'b0,
    PH_PARITY = 1'b1
  } enc_phase_e;
endpackage

// File: rtl/bch_par_lfsr.sv
`timescale 1ns/1ps
// Remainder register: divides message*x^PAR_W by the generator, then drains MSB first.
module bch_par_lfsr #(
  parameter int          PAR_W    = 8,
  parameter logic [PAR_W:0] GEN_POLY = 9'h1D1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic absorb,
  input  logic restart,
  input  logic din,
  input  logic drain,
  output logic par_msb
);
  logic [PAR_W-1:0] rem_q;
  logic [PAR_W-1:0] base;
  logic [PAR_W-1:0] rem_d;
  logic             fb;

  always_comb begin
    base = restart ? '0 : rem_q;
    fb   = din ^ base[PAR_W-1];
    if (absorb)
      rem_d = {base[PAR_W-2:0], 1'b0} ^ (fb ? GEN_POLY[PAR_W-1:0] : '0);
    else
      rem_d = {rem_q[PAR_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst)
      rem_q <= '0;
    else if (en && (absorb || drain))
      rem_q <= rem_d;
  end

  assign par_msb = rem_q[PAR_W-1];

  // R7: with enable low the remainder does not move
  a_r7_rem_frozen: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(rem_q));
endmodule

// File: rtl/bch_word_seq.sv
`timescale 1ns/1ps
// Word sequencer: counts message bits, then parity slots.
module bch_word_seq
  import bch_enc_pkg::*;
#(
  parameter int K     = 7,
  parameter int PAR_W = 8,
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_fire,
  input  logic       par_fire,
  input  logic       in_start,
  output enc_phase_e phase,
  output logic       first_bit
);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(K - 1);
  localparam logic [CNT_W-1:0] LAST_PAR  = CNT_W'(PAR_W - 1);

  logic [CNT_W-1:0] dcnt_q;
  logic [CNT_W-1:0] pcnt_q;
  logic [CNT_W-1:0] dbase;

  assign dbase     = in_start ? '0 : dcnt_q;
  assign first_bit = (dbase == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_DATA;
      dcnt_q <= '0;
      pcnt_q <= '0;
    end else begin
      if (in_fire) begin
        if (dbase == LAST_DATA) begin
          phase  <= PH_PARITY;
          dcnt_q <= '0;
        end else begin
          dcnt_q <= dbase + 1'b1;
        end
      end
      if (par_fire) begin
        if (pcnt_q == LAST_PAR) begin
          phase  <= PH_DATA;
          pcnt_q <= '0;
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
        end
      end
    end
  end

  // R3: the parity tail cannot end without emitting its last slot
  a_r3_parity_span: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PARITY) && !par_fire |=> (phase == PH_PARITY));
endmodule

// File: rtl/bch_serial_enc.sv
`timescale 1ns/1ps
module bch_serial_enc
  import bch_enc_pkg::*;
#(
  parameter int             M        = 4,
  parameter int             T        = 2,
  parameter int             PAR_W    = M * T,
  parameter int             K        = (2 ** M - 1) - PAR_W,
  parameter logic [PAR_W:0] GEN_POLY = 9'h1D1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_start,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_start
);
  localparam int N_FULL = 2 ** M - 1;
  localparam int CNT_W  = $clog2(N_FULL + 1);

  enc_phase_e phase;
  logic       first_bit;
  logic       par_msb;
  logic       slot_free;
  logic       in_fire;
  logic       par_fire;

  assign slot_free = !out_valid || out_ready;
  assign in_ready  = en && (phase == PH_DATA) && slot_free;
  assign in_fire   = in_ready && in_valid;
  assign par_fire  = en && (phase == PH_PARITY) && slot_free;

  bch_word_seq #(
    .K     (K),
    .PAR_W (PAR_W),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_fire   (in_fire),
    .par_fire  (par_fire),
    .in_start  (in_start),
    .phase     (phase),
    .first_bit (first_bit)
  );

  bch_par_lfsr #(
    .PAR_W    (PAR_W),
    .GEN_POLY (GEN_POLY)
  ) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .absorb  (in_fire),
    .restart (in_start),
    .din     (in_bit),
    .drain   (par_fire),
    .par_msb (par_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_start <= 1'b0;
    end else if (en) begin
      if (in_fire) begin
        out_valid <= 1'b1;
        out_bit   <= in_bit;
        out_start <= first_bit;
      end else if (par_fire) begin
        out_valid <= 1'b1;
        out_bit   <= par_msb;
        out_start <= 1'b0;
      end else if (out_ready) begin
        out_valid <= 1'b0;
        out_start <= 1'b0;
      end
    end
  end

  // R1: reset empties the output stage
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid && !out_start);

  // R5: a stalled output holds
  a_r5_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    out_valid && !(en && out_ready) |=> out_valid && $stable(out_bit) && $stable(out_start));

  // R6: an accepted bit is presented one clock later
  a_r6_pass_through: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && (out_bit == $past(in_bit)));

  // R4: a start marker never stands without a valid bit
  a_r4_start_valid: assert property (@(posedge clk) disable iff (rst)
    out_start |-> out_valid);
endmodule

// File: tb/bch_serial_enc_tb.sv
`timescale 1ns/1ps
module bch_serial_enc_tb;
  localparam int K = 7;
  localparam int P = 8;
  localparam int N = K + P;
  localparam logic [P:0] G = 9'h1D1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_start = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_bit, out_start;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit stall_mode = 0;
  logic [31:0] prng = 32'h1234_5678;

  bit exp_bit[$];
  bit exp_st[$];

  always #4 clk = ~clk;

  bch_serial_enc u_dut (
    .clk(clk), .rst(rst), .en(en),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .in_start(in_start),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .out_start(out_start)
  );

  function automatic logic [P-1:0] poly_mod(input logic [N-1:0] v);
    logic [N-1:0] w;
    logic [N-1:0] g_ext;
    w = v;
    g_ext = {{(N-P-1){1'b0}}, G};
    for (int i = N - 1; i >= P; i--)
      if (w[i]) w = w ^ (g_ext << (i - P));
    return w[P-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // sink stall pattern
  initial forever begin
    @(posedge clk); #1;
    prng = prng ^ (prng << 13);
    prng = prng ^ (prng >> 17);
    prng = prng ^ (prng << 5);
    out_ready = stall_mode ? prng[3] : 1'b1;
  end

  // monitor / scoreboard
  bit held = 0;
  bit held_bit = 0;
  int cw_cnt = 0;
  logic [N-1:0] cw = '0;
  initial forever begin
    @(negedge clk);
    if (rst) begin
      exp_bit.delete();
      exp_st.delete();
      held = 0;
      cw_cnt = 0;
    end else begin
      if (held)  // R5
        check(out_valid && out_bit == held_bit, "R5 hold", int'(out_bit), int'(held_bit));
      held = en && out_valid && !out_ready;
      held_bit = out_bit;
      if (en && out_valid && out_ready) begin
        if (exp_bit.size() == 0) begin
          check(0, "R2 unexpected output bit", int'(out_bit), -1);
        end else begin
          bit eb, es;
          eb = exp_bit.pop_front();
          es = exp_st.pop_front();
          check(out_bit == eb, "R2 codeword bit", int'(out_bit), int'(eb));
          check(out_start == es, "R4 start flag", int'(out_start), int'(es));
        end
        if (out_start) cw_cnt = 0;
        cw = {cw[N-2:0], out_bit};
        cw_cnt++;
        if (cw_cnt == N) begin  // R8
          check(poly_mod(cw) == '0, "R8 divisible", int'(poly_mod(cw)), 0);
          cw_cnt = 0;
        end
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  task automatic send_bit(input bit b, input bit s, input bit first);
    bit ok;
    in_valid = 1'b1;
    in_bit = b;
    in_start = s;
    do begin
      @(negedge clk);
      ok = in_ready && in_valid;
      @(posedge clk); #1;
    end while (!ok);
    exp_bit.push_back(b);
    exp_st.push_back(first);
    in_valid = 1'b0;
    in_start = 1'b0;
  endtask

  task automatic push_parity(input logic [K-1:0] msg);
    logic [P-1:0] par;
    par = poly_mod({msg, {P{1'b0}}});
    for (int i = P - 1; i >= 0; i--) begin
      exp_bit.push_back(par[i]);
      exp_st.push_back(1'b0);
    end
  endtask

  task automatic send_word(input logic [K-1:0] msg, input bit with_start);
    for (int i = K - 1; i >= 0; i--)
      send_bit(msg[i], with_start && (i == K - 1), i == K - 1);
    push_parity(msg);
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_bit.size() != 0; i++) @(posedge clk);
    #1;
    check(exp_bit.size() == 0, "R2 all bits emitted", exp_bit.size(), 0);
  endtask

  initial begin
    int gap;
    logic [K-1:0] msg;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    @(posedge clk); #1;

    // R6 latency on the first bit, then R2 with message 0000001
    send_bit(1'b0, 1'b1, 1'b1);
    check(out_valid && out_bit == 1'b0 && out_start, "R6 one-clock pass", int'(out_valid), 1);
    for (int i = K - 2; i >= 0; i--) send_bit(i == 0, 1'b0, 1'b0);
    push_parity(7'b0000001);
    // R3 parity gap length with a free sink
    gap = 0;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      gap++;
    end
    check(gap == P, "R3 ready low for parity", gap, P);
    @(posedge clk); #1;
    drain();

    // assorted patterns, free sink
    send_word(7'b1000000, 1'b1);
    send_word(7'b0000000, 1'b1);
    send_word(7'b1111111, 1'b0);
    send_word(7'b1010101, 1'b1);
    drain();

    // same with stalling sink
    stall_mode = 1;
    for (int w = 0; w < 12; w++) begin
      msg = prng[K+3:4] ^ K'(w * 37);
      send_word(msg, w[0]);
    end
    send_word(7'b1111111, 1'b1);
    drain();
    stall_mode = 0;
    @(posedge clk); #1;

    // R4 restart mid-word: three bits then a fresh word
    send_bit(1'b1, 1'b1, 1'b1);
    send_bit(1'b1, 1'b0, 1'b0);
    send_bit(1'b0, 1'b0, 1'b0);
    send_word(7'b0110010, 1'b1);
    drain();

    // R7 enable low in the middle of a word, garbage on the input
    msg = 7'b1100101;
    send_bit(msg[6], 1'b1, 1'b1);
    send_bit(msg[5], 1'b0, 1'b0);
    send_bit(msg[4], 1'b0, 1'b0);
    en = 1'b0;
    in_valid = 1'b1;
    in_start = 1'b1;
    in_bit = 1'b1;
    repeat (6) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R7 in_ready low while disabled", int'(in_ready), 0);
      check(out_valid && out_bit == msg[4], "R7 output held while disabled", int'(out_bit), int'(msg[4]));
    end
    @(posedge clk); #1;
    en = 1'b1;
    in_valid = 1'b0;
    in_start = 1'b0;
    for (int i = 3; i >= 0; i--) send_bit(msg[i], 1'b0, 1'b0);
    push_parity(msg);
    drain();

    // R1 reset in the middle of the parity tail
    send_word(7'b0101100, 1'b1);
    repeat (3) @(posedge clk);
    #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after mid-tail reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after mid-tail reset", int'(in_ready), 1);
    @(posedge clk); #1;
    send_word(7'b0011011, 1'b0);
    drain();

    finish_run();
  end
endmodule